// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target Engine

This block is the bus-facing half of an 8K x 8 serial memory. It samples the two-wire clock and data lines with the system clock, cleans them with a synchronizer and a short majority-free window filter, and recognises START and STOP conditions. It shifts bytes in most significant bit first and checks the device-select byte against a fixed device code and three strap inputs. It then either takes a two-byte word address followed by write data, or returns read data. It pulls the data line low through an output enable and never drives it high.

Towards the storage side it offers a combinational read port addressed by its internal pointer and a page-buffer write port that receives one strobe per accepted data byte. A commit pulse at STOP tells the nonvolatile write sequencer to program the buffered page. That sequencer reports back through a busy input. While busy is high the engine acknowledges nothing, so a host can poll for completion by retrying the select byte.

Top module: `i2cs_eeprom_engine`

## Requirements
- R1: A falling data edge while the clock is high is a START; a rising data edge while the clock is high is a STOP. A START in any state, including the middle of an address phase, restarts reception at the select byte and leaves the pointer unchanged.
- R2: The select byte is accepted only when bits 7..4 equal binary 1010 and bits 3..1 equal the strap inputs, where strap bit 2 is compared to bit 3. Bit 0 set means read. On a mismatch no ACK is given and every later byte is ignored until the next START.
- R3: Each accepted byte is acknowledged by holding the data line low for the whole high phase of the ninth clock.
- R4: While the busy input is high, no ACK is given for any byte. A busy device therefore looks absent, and it answers again once busy is low.
- R5: After a write select byte, an address high byte and an address low byte follow. Only the low 13 bits are used, so the top three bits of the high byte are ignored.
- R6: Each data byte after the address produces one page-buffer write strobe carrying the pointer and the byte. Only the low 5 pointer bits then advance, wrapping inside the 32-byte page.
- R7: A STOP after at least one data byte gives a one-cycle commit pulse. A STOP or repeated START with no data byte gives none.
- R8: A repeated START after the address bytes, followed by a read select byte, returns the byte at the loaded address.
- R9: A read select byte with no address phase returns the byte at the current pointer. After any read or data byte, the pointer addresses the location after the last one accessed.
- R10: Each byte sent advances the full 13-bit pointer. A master ACK fetches the next byte, and the pointer wraps from 0x1FFF to 0x0000.
- R11: After a master NACK the block releases the data line and ignores further clocks until START or STOP.
- R12: While the clock stays high, the data-line enable does not change, except as a result of a START or STOP. Enable changes follow a seen clock fall with one extra system-clock hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Two-wire clock line level |
| sda_i | input | 1 | Two-wire data line level |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| strap_i | input | 3 | Chip-select straps compared with select byte bits 3..1 |
| busy_i | input | 1 | Nonvolatile write cycle in progress |
| rd_addr_o | output | ADDR_W | Read port address (current pointer) |
| rd_data_i | input | 8 | Read port data, valid in the same cycle |
| pb_we_o | output | 1 | Page-buffer write strobe |
| pb_addr_o | output | ADDR_W | Page-buffer write address |
| pb_data_o | output | 8 | Page-buffer write data |
| commit_o | output | 1 | One-cycle pulse: program the buffered page |

## Verification
The bench builds the block with its defaults: a 13-bit address, a 5-bit page index and a 3-sample filter, with the straps tied to 101. It clocks the bus at one quarter period per 16 system clocks. The full-width address lets a single random read at 0x1FFE reach the 0x1FFF-to-0x0000 wrap. The 32-byte page lets a 34-byte burst cross the page wrap twice within the run. With three strap bits, all eight chip-select codes can be swept, and each one's ACK result is checked against the strap value.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   localparam logic [3:0] DEV_CODE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RDAT
   } eng_state_t;
endpackage

// File: rtl/i2cs_line_filt.sv
module i2cs_line_filt #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [1:0] sync_q;
   logic       lvl_q;
   logic       prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], line_i};
   end

   generate
      if (FILT_LEN == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b1;
            else        lvl_q <= sync_q[1];
         end
      end else begin : g_window
         logic [FILT_LEN-1:0] win_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q <= '1;
               lvl_q <= 1'b1;
            end else begin
               win_q <= {win_q[FILT_LEN-2:0], sync_q[1]};
               if (&win_q)       lvl_q <= 1'b1;
               else if (~|win_q) lvl_q <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl_q;
   end

   assign level_o = lvl_q;
   assign rise_o  = lvl_q & ~prev_q;
   assign fall_o  = ~lvl_q & prev_q;
endmodule

// File: rtl/i2cs_addr_ptr.sv
module i2cs_addr_ptr #(
   parameter int ADDR_W = 13,
   parameter int PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              inc_page_i,
   input  logic              inc_seq_i,
   output logic [ADDR_W-1:0] ptr_o
);
   logic [ADDR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr_q <= '0;
      else if (load_i)     ptr_q <= load_val_i;
      else if (inc_seq_i)  ptr_q <= ptr_q + 1'b1;
      else if (inc_page_i) ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
   end

   assign ptr_o = ptr_q;

   // R10
   seq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_seq_i && !load_i && (&ptr_q)) |=> (ptr_q == '0));

   // R6
   page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_page_i && !load_i && !inc_seq_i) |=>
      (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/i2cs_eeprom_engine.sv
module i2cs_eeprom_engine
   import i2cs_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int PAGE_W   = 5,
   parameter int FILT_LEN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [2:0]        strap_i,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i,
   output logic              pb_we_o,
   output logic [ADDR_W-1:0] pb_addr_o,
   output logic [7:0]        pb_data_o,
   output logic              commit_o
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 9..16");
      end
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("PAGE_W must lie in 1..ADDR_W-1");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
   endgenerate

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;

   i2cs_line_filt #(.FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   i2cs_line_filt #(.FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   logic start_ev, stop_ev;
   assign start_ev = sda_fall & scl_lvl;
   assign stop_ev  = sda_rise & scl_lvl;

   eng_state_t        state_q;
   logic [3:0]        bitcnt_q;
   logic              ackph_q;
   logic [7:0]        shreg_q;
   logic [HI_W-1:0]   hi_q;
   logic              rw_q;
   logic              mack_q;
   logic              wrote_q;
   logic              drive_q;
   logic [ADDR_W-1:0] ptr;

   logic active, decide, ack_end, sel_match, ack_ok;
   logic do_load, do_inc_page, do_fetch;

   assign active    = !start_ev && !stop_ev && (state_q != ST_IDLE);
   assign decide    = active && scl_fall && !ackph_q && (bitcnt_q == 4'd8)
                      && (state_q != ST_RDAT);
   assign ack_end   = active && scl_fall && ackph_q;
   assign sel_match = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == strap_i);
   assign ack_ok    = !busy_i && ((state_q != ST_CTRL) || sel_match);
   assign do_load     = decide && ack_ok && (state_q == ST_ALO);
   assign do_inc_page = decide && ack_ok && (state_q == ST_WDAT);
   assign do_fetch    = ack_end && (((state_q == ST_CTRL) && rw_q) ||
                                    ((state_q == ST_RDAT) && mack_q));

   i2cs_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load_i(do_load), .load_val_i({hi_q, shreg_q}),
      .inc_page_i(do_inc_page), .inc_seq_i(do_fetch),
      .ptr_o(ptr));

   assign rd_addr_o = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bitcnt_q  <= '0;
         ackph_q   <= 1'b0;
         shreg_q   <= '0;
         hi_q      <= '0;
         rw_q      <= 1'b0;
         mack_q    <= 1'b0;
         wrote_q   <= 1'b0;
         drive_q   <= 1'b0;
         sda_oe_o  <= 1'b0;
         pb_we_o   <= 1'b0;
         pb_addr_o <= '0;
         pb_data_o <= '0;
         commit_o  <= 1'b0;
      end else begin
         pb_we_o  <= 1'b0;
         commit_o <= 1'b0;
         sda_oe_o <= drive_q;
         if (start_ev) begin
            state_q  <= ST_CTRL;
            bitcnt_q <= '0;
            ackph_q  <= 1'b0;
            drive_q  <= 1'b0;
            wrote_q  <= 1'b0;
         end else if (stop_ev) begin
            state_q  <= ST_IDLE;
            ackph_q  <= 1'b0;
            drive_q  <= 1'b0;
            commit_o <= wrote_q;
            wrote_q  <= 1'b0;
         end else if (state_q != ST_IDLE) begin
            if (scl_rise) begin
               if (ackph_q) begin
                  mack_q <= ~sda_lvl;
               end else if (bitcnt_q < 4'd8) begin
                  bitcnt_q <= bitcnt_q + 1'b1;
                  if (state_q != ST_RDAT) shreg_q <= {shreg_q[6:0], sda_lvl};
               end
            end else if (scl_fall) begin
               if (ackph_q) begin
                  ackph_q  <= 1'b0;
                  bitcnt_q <= '0;
                  drive_q  <= 1'b0;
                  unique case (state_q)
                     ST_CTRL: state_q <= rw_q ? ST_RDAT : ST_AHI;
                     ST_AHI:  state_q <= ST_ALO;
                     ST_ALO:  state_q <= ST_WDAT;
                     ST_RDAT: if (!mack_q) state_q <= ST_IDLE;
                     default: state_q <= state_q;
                  endcase
                  if (do_fetch) begin
                     shreg_q <= rd_data_i;
                     drive_q <= ~rd_data_i[7];
                  end
               end else if (bitcnt_q == 4'd8) begin
                  if (state_q == ST_RDAT) begin
                     drive_q <= 1'b0;
                     ackph_q <= 1'b1;
                  end else if (!ack_ok) begin
                     state_q <= ST_IDLE;
                     drive_q <= 1'b0;
                  end else begin
                     ackph_q <= 1'b1;
                     drive_q <= 1'b1;
                     if (state_q == ST_CTRL) rw_q <= shreg_q[0];
                     if (state_q == ST_AHI)  hi_q <= shreg_q[HI_W-1:0];
                     if (state_q == ST_WDAT) begin
                        pb_we_o   <= 1'b1;
                        pb_addr_o <= ptr;
                        pb_data_o <= shreg_q;
                        wrote_q   <= 1'b1;
                     end
                  end
               end else if (state_q == ST_RDAT && bitcnt_q != 4'd0) begin
                  shreg_q <= {shreg_q[6:0], 1'b0};
                  drive_q <= ~shreg_q[6];
               end
            end
         end
      end
   end

   // R1
   start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (state_q == ST_CTRL && bitcnt_q == 4'd0 && !ackph_q));

   // R4
   busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && busy_i) |=> !drive_q);

   // R12
   oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl) && $past(scl_lvl, 2) &&
       !$past(start_ev, 2) && !$past(stop_ev, 2)) |-> $stable(sda_oe_o));
endmodule

// File: tb/i2cs_eeprom_engine_bench.sv
module i2cs_eeprom_engine_bench;
   localparam int         Q     = 16;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] CW    = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] CR    = {4'b1010, STRAP, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic busy = 1'b0;
   logic sda_oe, pb_we, commit;
   logic [12:0] rd_addr, pb_addr;
   logic [7:0]  rd_data, pb_data;
   wire sda_bus = m_sda & ~sda_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int n_commit = 0;
   int n_pb = 0;
   logic [12:0] log_addr [0:63];
   logic [7:0]  log_data [0:63];

   always #5 clk = ~clk;

   function automatic logic [7:0] mval(input logic [12:0] a);
      return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
   endfunction

   assign rd_data = mval(rd_addr);

   i2cs_eeprom_engine u_i2cs_eeprom_engine (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .strap_i(STRAP), .busy_i(busy),
      .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .pb_we_o(pb_we), .pb_addr_o(pb_addr), .pb_data_o(pb_data),
      .commit_o(commit));

   always @(negedge clk) begin
      if (commit) n_commit <= n_commit + 1;
      if (pb_we) begin
         if (n_pb < 64) begin
            log_addr[n_pb] <= pb_addr;
            log_data[n_pb] <= pb_data;
         end
         n_pb <= n_pb + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b0; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b1; wq(); wq();
   endtask

   task automatic wr_byte(input logic [7:0] b, output bit ack);
      logic s1, s2;
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq();
         m_scl = 1'b1; wq(); wq();
         m_scl = 1'b0; wq();
      end
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      s1 = sda_bus; wq();
      s2 = sda_bus;
      m_scl = 1'b0; wq();
      ack = !s1 && !s2;
   endtask

   task automatic rd_byte(input bit give_ack, output logic [7:0] b);
      logic s1, s2;
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq();
         m_scl = 1'b1; wq();
         s1 = sda_bus; wq();
         s2 = sda_bus;
         m_scl = 1'b0;
         b[i] = s1;
         // R12: the line holds through the high phase
         chk(s1 == s2, "R12 stable while clock high", int'(s2), int'(s1));
      end
      wq();
      m_sda = !give_ack; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0; wq();
      m_sda = 1'b1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] rb;
      int c0, p0;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // R3 reset: line released, no strobes
      chk(sda_oe == 1'b0 && pb_we == 1'b0 && commit == 1'b0, "R3 reset idle",
          int'({sda_oe, pb_we, commit}), 0);

      // R2 sweep all chip-select codes
      for (int cs = 0; cs < 8; cs++) begin
         c0 = n_commit;
         bus_start();
         wr_byte({4'b1010, 3'(cs), 1'b0}, ack);
         chk(ack == (3'(cs) == STRAP), "R2 select compare", int'(ack), int'(3'(cs) == STRAP));
         if (!ack) begin
            wr_byte(8'h00, ack);
            chk(!ack, "R2 later byte ignored", int'(ack), 0);
         end
         bus_stop();
         chk(n_commit == c0, "R7 no data no commit", n_commit, c0);
      end

      // R2 wrong device code
      bus_start();
      wr_byte({4'b1011, STRAP, 1'b0}, ack);
      chk(!ack, "R2 wrong device code", int'(ack), 0);
      bus_stop();

      // byte write: R3 R5 R6 R7
      c0 = n_commit; p0 = n_pb;
      bus_start();
      wr_byte(CW, ack);    chk(ack, "R3 ack select", int'(ack), 1);
      wr_byte(8'hE1, ack); chk(ack, "R3 ack addr high", int'(ack), 1);
      wr_byte(8'h23, ack); chk(ack, "R3 ack addr low", int'(ack), 1);
      wr_byte(8'h77, ack); chk(ack, "R3 ack data", int'(ack), 1);
      bus_stop();
      chk(n_pb == p0 + 1, "R6 one strobe", n_pb, p0 + 1);
      chk(log_addr[p0] == 13'h0123, "R5 top bits ignored", int'(log_addr[p0]), 'h123);
      chk(log_data[p0] == 8'h77, "R6 data", int'(log_data[p0]), 'h77);
      chk(n_commit == c0 + 1, "R7 commit", n_commit, c0 + 1);

      // R9 current address read after byte write
      bus_start();
      wr_byte(CR, ack); chk(ack, "R9 read select ack", int'(ack), 1);
      rd_byte(1'b0, rb);
      chk(rb == mval(13'h0124), "R9 current read", int'(rb), int'(mval(13'h0124)));
      bus_stop();

      // R6 page write of 34 bytes from offset 30
      c0 = n_commit; p0 = n_pb;
      bus_start();
      wr_byte(CW, ack); wr_byte(8'h0A, ack); wr_byte(8'h1E, ack);
      for (int i = 0; i < 34; i++) begin
         wr_byte(8'(i * 7 + 3), ack);
         chk(ack, "R3 page data ack", int'(ack), 1);
      end
      bus_stop();
      chk(n_pb == p0 + 34, "R6 strobe count", n_pb, p0 + 34);
      for (int i = 0; i < 34; i++) begin
         chk(log_addr[p0 + i] == (13'h0A00 | 13'((30 + i) % 32)), "R6 page wrap addr",
             int'(log_addr[p0 + i]), int'(13'h0A00 | 13'((30 + i) % 32)));
         chk(log_data[p0 + i] == 8'(i * 7 + 3), "R6 page data",
             int'(log_data[p0 + i]), int'(8'(i * 7 + 3)));
      end
      chk(n_commit == c0 + 1, "R7 page commit", n_commit, c0 + 1);

      bus_start();
      wr_byte(CR, ack);
      rd_byte(1'b0, rb);
      chk(rb == mval(13'h0A00), "R9 pointer after page", int'(rb), int'(mval(13'h0A00)));
      bus_stop();

      // R8 random read, R10 sequential wrap, R11 after NACK
      c0 = n_commit;
      bus_start();
      wr_byte(CW, ack); wr_byte(8'h1F, ack); wr_byte(8'hFE, ack);
      bus_start();
      wr_byte(CR, ack); chk(ack, "R8 read select after restart", int'(ack), 1);
      rd_byte(1'b1, rb);
      chk(rb == mval(13'h1FFE), "R8 random read", int'(rb), int'(mval(13'h1FFE)));
      rd_byte(1'b1, rb);
      chk(rb == mval(13'h1FFF), "R10 sequential", int'(rb), int'(mval(13'h1FFF)));
      rd_byte(1'b0, rb);
      chk(rb == mval(13'h0000), "R10 wrap to zero", int'(rb), int'(mval(13'h0000)));
      rd_byte(1'b0, rb);
      chk(rb == 8'hFF, "R11 released after NACK", int'(rb), 'hFF);
      bus_stop();
      chk(n_commit == c0, "R7 restart no commit", n_commit, c0);

      // R4 busy hides the device
      busy = 1'b1;
      bus_start();
      wr_byte(CW, ack); chk(!ack, "R4 busy no ack", int'(ack), 0);
      bus_stop();
      busy = 1'b0;

      // R1 START aborts an address phase, pointer kept
      bus_start();
      wr_byte(CW, ack); chk(ack, "R4 ack after busy", int'(ack), 1);
      wr_byte(8'h05, ack);
      bus_start();
      wr_byte(CR, ack); chk(ack, "R1 restart select", int'(ack), 1);
      rd_byte(1'b0, rb);
      chk(rb == mval(13'h0001), "R1 abort keeps pointer", int'(rb), int'(mval(13'h0001)));
      bus_stop();

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule